// File: doc/BRIEF.md
# Hot-Swap Insertion and Removal Status Register

This block keeps the insertion and removal state of a hot-swappable add-in card. It watches four inputs. The first is the board status line, which follows the ejector handle and arrives asynchronously. The other three are the bus reset, the serial-preload-complete flag and the lockout flag. From these it keeps two sticky flags. The insertion flag says the card is ready for the host to initialize it. The removal flag says an extraction is about to happen.

While either flag is set, the block pulls an open-drain enumeration request toward the host. It also owns the output enable of the shared status line. The block drives that line while a removal is pending. It releases the line to high impedance once software has acknowledged the removal.

Software reads one status word and acknowledges events by writing ones to the flag positions through a simple byte-enabled write port. A write of zero to a flag leaves that flag unchanged.

Top module: `hs_status_reg`

## Requirements
- R1: After reset, both flags are 0, `rd_data` is all zeros, `enum_drive_low` is 0 and `stat_oe` is 0.
- R2: `stat_in` passes through a two-stage synchronizer. A change at the input first affects the set conditions at the second rising edge after it. The removal flag therefore becomes visible on `rd_data` after the third edge.
- R3: The removal flag sets when the synchronized status line is 1 and `bus_rst_n` is 1. It never sets while `bus_rst_n` is 0. The condition is a level: if the flag is cleared while the condition still holds, it sets again.
- R4: The insertion flag sets when the ready condition appears. The ready condition is the synchronized status line at 0, `preload_done` at 1 and `lockout` at 0. Missing any one of the three blocks it.
- R5: The insertion flag is edge-qualified. It sets once on each entry into the ready condition. After software clears it, it does not set again while the condition merely persists.
- R6: A write with `wr_en`=1 and `wr_be[0]`=1 clears the insertion flag where `wr_data[7]`=1 and clears the removal flag where `wr_data[6]`=1. Zero data bits leave the flags unchanged. A write with `wr_be[0]`=0 leaves both flags unchanged.
- R7: When a set condition and a write-1 clear of the same flag fall in the same cycle, the flag ends up set.
- R8: `enum_drive_low` is a registered open-drain enable. It is 1 in the cycle after either flag is 1 and 0 in the cycle after both flags are 0.
- R9: `stat_oe` is registered and follows the removal flag one cycle later. Clearing the removal flag therefore releases the status line on the next edge.
- R10: `rd_data` carries the insertion flag in bit 7 and the removal flag in bit 6. Reserved bits 5:4 and all other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_in | input | 1 | Board status line (ejector), asynchronous |
| bus_rst_n | input | 1 | Bus reset, active low |
| preload_done | input | 1 | Serial preload has finished |
| lockout | input | 1 | Lockout bit; 1 holds off insertion |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | DATA_W/8 (2) | Byte enables of the write |
| wr_data | input | DATA_W (16) | Write data, ones clear flags |
| rd_data | output | DATA_W (16) | Status word read back |
| enum_drive_low | output | 1 | Open-drain enumeration pull-low enable |
| stat_oe | output | 1 | Output enable of the shared status line |

## Verification
Within one cycle, the set logic of a flag and a software write-1 clear of that same flag can both act. The bench provokes this for the removal flag by writing its clear bit while the removal condition is held. It provokes it for the insertion flag by raising `preload_done` in the very cycle that carries the clear. In both cases the flag must read back as 1.

A cycle-by-cycle reference model in the bench tracks every input combination through a sweep of write patterns. It judges these collisions, along with the synchronizer delay and the registered outputs, at each edge.

// File: rtl/hs_status_pkg.sv
package hs_status_pkg;

  // Condition under which the card is ready for host initialization.
  function automatic logic ready_cond(input logic line_s, input logic pre_done,
                                      input logic lock);
    return (!line_s) && pre_done && (!lock);
  endfunction

  // Condition that announces an imminent extraction.
  function automatic logic removal_cond(input logic line_s, input logic brst_n);
    return line_s && brst_n;
  endfunction

  // A write-one-to-clear hit on one bit lane.
  function automatic logic w1c_hit(input logic en, input logic lane_be,
                                   input logic bit_val);
    return en && lane_be && bit_val;
  endfunction

  // Next value of a sticky flag, set has priority over clear.
  function automatic logic sticky_next(input logic cur, input logic set_i,
                                       input logic clr_i);
    return set_i || (cur && !clr_i);
  endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= 1'b0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= 1'b0;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/hs_event_det.sv
module hs_event_det
  import hs_status_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line_s,
  input  logic bus_rst_n,
  input  logic preload_done,
  input  logic lockout,
  output logic rem_set,
  output logic ins_set
);
  logic ready_now;
  logic ready_q;

  assign ready_now = ready_cond(line_s, preload_done, lockout);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ready_now;
  end

  assign ins_set = ready_now && !ready_q;
  assign rem_set = removal_cond(line_s, bus_rst_n);

  AST_INS_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    ins_set |=> !ins_set); // R5

endmodule

// File: rtl/hs_w1c_bit.sv
module hs_w1c_bit
  import hs_status_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= sticky_next(q, set_i, clr_i);
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q); // R7

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q); // R6

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q)); // R6

endmodule

// File: rtl/hs_pin_ctrl.sv
module hs_pin_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ins_q,
  input  logic rem_q,
  output logic enum_drive_low,
  output logic stat_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enum_drive_low <= 1'b0;
      stat_oe        <= 1'b0;
    end else begin
      enum_drive_low <= ins_q || rem_q;
      stat_oe        <= rem_q;
    end
  end

  AST_ENUM_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_q || rem_q) |=> enum_drive_low); // R8

  AST_ENUM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_q && !rem_q) |=> !enum_drive_low); // R8

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rem_q) |=> !stat_oe); // R9

endmodule

// File: rtl/hs_status_reg.sv
module hs_status_reg
  import hs_status_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int REM_BIT     = 6,
  parameter int INS_BIT     = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stat_in,
  input  logic                  bus_rst_n,
  input  logic                  preload_done,
  input  logic                  lockout,
  input  logic                  wr_en,
  input  logic [DATA_W/8-1:0]   wr_be,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  enum_drive_low,
  output logic                  stat_oe
);
  localparam int BE_W     = DATA_W / 8;
  localparam int NFLAGS   = 2;
  localparam int REM_LANE = REM_BIT / 8;
  localparam int INS_LANE = INS_BIT / 8;

  logic              line_s;
  logic              rem_set;
  logic              ins_set;
  logic [NFLAGS-1:0] set_vec;
  logic [NFLAGS-1:0] clr_vec;
  logic [NFLAGS-1:0] flag_q;
  logic              rem_q;
  logic              ins_q;
  logic              unused_wr;

  hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (stat_in),
    .q     (line_s)
  );

  hs_event_det u_det (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_s       (line_s),
    .bus_rst_n    (bus_rst_n),
    .preload_done (preload_done),
    .lockout      (lockout),
    .rem_set      (rem_set),
    .ins_set      (ins_set)
  );

  // Flag 0 is removal, flag 1 is insertion.
  assign set_vec    = {ins_set, rem_set};
  assign clr_vec[0] = w1c_hit(wr_en, wr_be[REM_LANE], wr_data[REM_BIT]);
  assign clr_vec[1] = w1c_hit(wr_en, wr_be[INS_LANE], wr_data[INS_BIT]);

  generate
    for (genvar f = 0; f < NFLAGS; f++) begin : g_flag
      hs_w1c_bit u_bit (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec[f]),
        .clr_i (clr_vec[f]),
        .q     (flag_q[f])
      );
    end
  endgenerate

  assign rem_q = flag_q[0];
  assign ins_q = flag_q[1];

  hs_pin_ctrl u_pins (
    .clk            (clk),
    .rst_n          (rst_n),
    .ins_q          (ins_q),
    .rem_q          (rem_q),
    .enum_drive_low (enum_drive_low),
    .stat_oe        (stat_oe)
  );

  always_comb begin
    rd_data          = '0;
    rd_data[REM_BIT] = rem_q;
    rd_data[INS_BIT] = ins_q;
  end

  assign unused_wr = ^{wr_data, wr_be, BE_W[0]};

  AST_REM_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rem_q) |-> $past(line_s && bus_rst_n)); // R3

  AST_INS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ins_q) |-> $past(!line_s && preload_done && !lockout)); // R4

  AST_OE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q |=> stat_oe); // R9

endmodule

// File: tb/tb_hs_status_reg.sv
`timescale 1ns/1ps
module tb_hs_status_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stat_in = 1'b0, bus_rst_n = 1'b0, preload_done = 1'b0, lockout = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] rd_data;
  logic        enum_drive_low, stat_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur = "R1";

  // reference model state
  logic m_s1 = 0, m_s2 = 0, m_rq = 0, m_ins = 0, m_rem = 0, m_en = 0, m_oe = 0;

  always #2.5 clk = ~clk;

  hs_status_reg dut (
    .clk(clk), .rst_n(rst_n), .stat_in(stat_in), .bus_rst_n(bus_rst_n),
    .preload_done(preload_done), .lockout(lockout), .wr_en(wr_en),
    .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data),
    .enum_drive_low(enum_drive_low), .stat_oe(stat_oe)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // One clock: advance the model from the requirements, then compare.
  task automatic step();
    logic rdy, ci, cr, n_ins, n_rem;
    @(posedge clk);
    rdy   = !m_s2 && preload_done && !lockout;              // R4
    ci    = wr_en && wr_be[0] && wr_data[7];                // R6
    cr    = wr_en && wr_be[0] && wr_data[6];
    n_ins = (rdy && !m_rq) || (m_ins && !ci);               // R5 R7
    n_rem = (m_s2 && bus_rst_n) || (m_rem && !cr);          // R3 R7
    m_en  = m_ins || m_rem;                                 // R8
    m_oe  = m_rem;                                          // R9
    m_s2  = m_s1;                                           // R2
    m_s1  = stat_in;
    m_rq  = rdy;
    m_ins = n_ins;
    m_rem = n_rem;
    #1;
    chk(cur, rd_data, {8'h00, m_ins, m_rem, 6'b000000});    // R10
    chk("R8", {15'h0, enum_drive_low}, {15'h0, m_en});
    chk("R9", {15'h0, stat_oe}, {15'h0, m_oe});
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    step();
    wr_en = 1'b0; wr_be = 2'b00; wr_data = 16'h0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #0.5;
    chk("R1", rd_data, 16'h0000);
    chk("R1", {15'h0, enum_drive_low}, 16'h0);
    chk("R1", {15'h0, stat_oe}, 16'h0);
    cur = "R1"; steps(2);

    // R3: line high but bus reset asserted, no removal
    cur = "R3"; stat_in = 1'b1; steps(6);
    chk("R3", rd_data, 16'h0000);
    bus_rst_n = 1'b1; steps(2);
    chk("R3", rd_data, 16'h0040);
    // R7: clear while the removal condition holds
    cur = "R7"; wr(2'b01, 16'h0040);
    chk("R7", rd_data, 16'h0040);
    // R6/R9: drop the line, then no-effect writes, then a real clear
    cur = "R6"; stat_in = 1'b0; steps(4);
    wr(2'b10, 16'hFFFF); chk("R6", rd_data, 16'h0040);
    wr(2'b01, 16'h0000); chk("R6", rd_data, 16'h0040);
    cur = "R9"; wr(2'b01, 16'h0040); chk("R9", rd_data, 16'h0000);
    step(); chk("R9", {15'h0, stat_oe}, 16'h0);

    // R4: lockout blocks insertion, clearing it lets it set
    cur = "R4"; lockout = 1'b1; preload_done = 1'b1; steps(3);
    chk("R4", rd_data, 16'h0000);
    lockout = 1'b0; steps(2);
    chk("R4", rd_data, 16'h0080);
    // R5: cleared and the condition persists, no re-set
    cur = "R5"; wr(2'b01, 16'h0080); steps(5);
    chk("R5", rd_data, 16'h0000);
    chk("R5", {15'h0, enum_drive_low}, 16'h0);
    // R7: new entry into ready in the same cycle as a clear
    cur = "R7"; preload_done = 1'b0; steps(1);
    wr(2'b01, 16'h0080);          // sets ins again? no: preload low
    preload_done = 1'b1; wr(2'b01, 16'h0080);
    chk("R7", rd_data, 16'h0080);
    wr(2'b01, 16'h0080); chk("R6", rd_data, 16'h0000);

    // R2: latency of the status line through the synchronizer
    cur = "R2"; preload_done = 1'b0; steps(2);
    stat_in = 1'b1; step(); step();
    chk("R2", rd_data, 16'h0000);
    step();
    chk("R2", rd_data, 16'h0040);
    step();
    chk("R2", {15'h0, stat_oe}, 16'h1);
    stat_in = 1'b0; steps(3); wr(2'b01, 16'h00C0); steps(2);

    // Sweep of input combinations against write patterns
    cur = "R10";
    for (int c = 0; c < 16; c++) begin
      for (int w = 0; w < 6; w++) begin
        stat_in = c[0]; bus_rst_n = c[1]; preload_done = c[2]; lockout = c[3];
        case (w)
          0: step();
          1: wr(2'b01, 16'h0040);
          2: wr(2'b01, 16'h0080);
          3: wr(2'b11, 16'h00C0);
          4: wr(2'b10, 16'h00C0);
          default: wr(2'b11, 16'hFF3F);
        endcase
        steps(2);
      end
    end
    finish_run();
  end
endmodule